// File: doc/BRIEF.md
# ADC Serial Output Frame Serializer

This block is the converter side of a read-only serial port on a sigma-delta style converter. A conversion engine hands it a signed result code with a done strobe. The block turns that code into a status-plus-data payload and shifts it out as a fixed-length frame on a single data line. An external master supplies the serial clock and an active-low select. The block runs on its own system clock. It synchronizes the select and serial clock inputs and reacts to their edges.

Before the first serial clock edge, the first frame bit is a live conversion-busy flag. It follows the converter state without any clocking, so a master can treat it as a ready indication. On the first falling serial edge after a conversion has completed, the latest result is frozen into the shift register. That falling edge and each later one present the next bit. The two leading payload bits carry the sign and, together, the out-of-range indication. Input codes beyond full scale saturate to fixed boundary codes. When deselected, the output driver is disabled and the data line is held at 0.

With the default sizes the frame is 32 bits. In the frame, bit 31 is the busy flag, bit 30 is a constant zero, bits 29..0 are the payload, and the payload is followed on the line by zeros. With N = RES_W + SUB_W, the payload is N+1 bits and the frame is N+3 bits. The signed input code is N+2 bits wide and full scale is FS = 2^(N-1).

Top module: `adc_frame_serializer`

## Requirements
- R1: After reset the output driver is disabled, the block reports busy, and a select with no completed conversion shows 1 on the data line.
- R2: While the synchronized select is high, sdo_oe is 0 and sdo_data is 0; serial clock edges in that state have no effect.
- R3: With select low and before the first falling serial edge of a frame, sdo_data equals the busy flag. It rises within three system clocks of a conv_start pulse and falls within three of a conv_done pulse, with no serial clock activity.
- R4: The first falling serial edge of a frame presents bit FRAME_W-2, which is always 0.
- R5: For an in-range code x (-FS <= x < FS), the payload equals x + 2^N as an unsigned N+1-bit value. Its top bit (frame bit FRAME_W-3) is therefore 1 for zero and positive codes and 0 for negative ones.
- R6: A code x >= FS yields payload bits 11 followed by zeros. A code x < -FS yields bits 00 followed by ones.
- R7: The payload is sent MSB first, one bit per falling serial edge. Frame bit 0 appears on falling edge FRAME_W-1.
- R8: Every falling serial edge after edge FRAME_W-1 drives sdo_data to 0 until select rises.
- R9: Once the first falling edge of a frame has occurred, a new conversion result does not change any bit of that frame.
- R10: Raising select in the middle of a frame aborts it. The next select-low shows the busy flag again and resends the whole frame from the dummy bit onward.
- R11: Rising serial clock edges never change sdo_data.
- R12: If the converter is busy, falling serial edges do not start a frame, and the data line keeps showing 1. When the conversion completes, the next falling edge starts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Pulse: a conversion begins (busy set) |
| conv_done | input | 1 | Pulse: conversion finished, conv_code valid (busy cleared) |
| conv_code | input | RES_W+SUB_W+2 | Signed conversion result |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| cs_n | input | 1 | Active-low select from the master (asynchronous) |
| sdo_data | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable; 0 means the line is high impedance |

## Verification
The bench runs a reduced configuration (RES_W=4, SUB_W=2). It reads a full frame plus two overrun edges for every one of the 256 signed input codes. This sweep covers both saturation regions, the codes on each full-scale boundary, zero, and both signs, so an off-by-one in a range comparison or in the offset shows up as a wrong leading pair. Separate sequences cover the cases where the frame content alone would not reveal a fault. The live busy flag is toggled with no serial clocks, and a result arrives in the middle of a frame. A frame is aborted and then resent. Serial clocks are pulsed while the block is deselected, and falling edges arrive while a conversion is still running. Each of these would produce a visibly shifted or altered bit stream if the corresponding rule were broken.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  // Leading non-payload bits of a frame: busy flag and constant zero,
  // plus the sign bit which is counted inside the payload.
  localparam int LEAD_BITS   = 2;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/adc_ser_sync.sv
module adc_ser_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= RST_VAL;
      else     stg[g] <= stg[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= stg[STAGES-1];
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/adc_ser_encode.sv
module adc_ser_encode #(
  parameter int N = 29
) (
  input  logic signed [N+1:0] code,
  output logic        [N:0]   payload
);
  localparam logic signed [N+1:0] FS_POS = signed'({2'b00, 1'b1, {(N-1){1'b0}}});
  localparam logic signed [N+1:0] FS_NEG = -FS_POS;
  localparam logic signed [N+1:0] OFFS   = signed'({1'b0, 1'b1, {N{1'b0}}});

  logic signed [N+1:0] shifted;

  always_comb begin
    shifted = code + OFFS;
    if (code >= FS_POS)     payload = {2'b11, {(N-1){1'b0}}};
    else if (code < FS_NEG) payload = {2'b00, {(N-1){1'b1}}};
    else                    payload = shifted[N:0];
  end
endmodule

// File: rtl/adc_ser_shift.sv
module adc_ser_shift #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_lvl,
  input  logic               sclk_fall,
  input  logic               busy,
  input  logic [FRAME_W-3:0] payload,
  output logic               sdo_oe,
  output logic               sdo_data
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam int PW = FRAME_W - 2;

  logic [CW-1:0] cnt;
  logic [PW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      sdo_oe   <= 1'b0;
      sdo_data <= 1'b0;
    end else if (cs_lvl) begin
      cnt      <= '0;
      sdo_oe   <= 1'b0;
      sdo_data <= 1'b0;
    end else begin
      sdo_oe <= 1'b1;
      if (cnt == '0) begin
        if (sclk_fall && !busy) begin
          sh       <= payload;
          sdo_data <= 1'b0;
          cnt      <= CW'(1);
        end else begin
          sdo_data <= busy;
        end
      end else if (sclk_fall) begin
        if (cnt != CW'(FRAME_W)) cnt <= cnt + CW'(1);
        if (cnt < CW'(FRAME_W - 1)) begin
          sdo_data <= sh[PW-1];
          sh       <= {sh[PW-2:0], 1'b0};
        end else begin
          sdo_data <= 1'b0;
        end
      end
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo_data); // R2
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(FRAME_W)); // R8
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(FRAME_W)) |-> !sdo_data); // R8
  AST_DUMMY_LOW: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1)) |-> !sdo_data); // R4
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !sclk_fall && !cs_lvl) |=> $stable(sh)); // R9
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && busy && !cs_lvl) |=> (cnt == '0)); // R12
endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer #(
  parameter int RES_W = 24,
  parameter int SUB_W = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           conv_start,
  input  logic                           conv_done,
  input  logic signed [RES_W+SUB_W+1:0]  conv_code,
  input  logic                           sclk,
  input  logic                           cs_n,
  output logic                           sdo_data,
  output logic                           sdo_oe
);
  localparam int N       = RES_W + SUB_W;
  localparam int FRAME_W = N + 1 + adc_ser_pkg::LEAD_BITS;

  localparam logic signed [N+1:0] FS_POS = signed'({2'b00, 1'b1, {(N-1){1'b0}}});
  localparam logic signed [N+1:0] FS_NEG = -FS_POS;

  logic [1:0] s_lvl, s_rise, s_fall;
  logic       busy;
  logic [N:0] enc_payload;
  logic [N:0] res_q;

  adc_ser_sync #(
    .W(2), .STAGES(adc_ser_pkg::SYNC_STAGES), .RST_VAL(2'b10)
  ) u_sync (
    .clk(clk), .rst(rst), .din({cs_n, sclk}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  adc_ser_encode #(.N(N)) u_enc (
    .code(conv_code), .payload(enc_payload)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b1;
      res_q <= '0;
    end else if (conv_done) begin
      busy  <= 1'b0;
      res_q <= enc_payload;
    end else if (conv_start) begin
      busy  <= 1'b1;
    end
  end

  adc_ser_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_lvl(s_lvl[1]), .sclk_fall(s_fall[0]),
    .busy(busy), .payload(res_q),
    .sdo_oe(sdo_oe), .sdo_data(sdo_data)
  );

  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (conv_code >= FS_NEG && conv_code < FS_POS) |-> (enc_payload[N] == !conv_code[N+1])); // R5
  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (rst)
    (conv_code >= FS_POS) |-> (enc_payload[N:N-1] == 2'b11)); // R6
  AST_UNDER_FLAG: assert property (@(posedge clk) disable iff (rst)
    (conv_code < FS_NEG) |-> (enc_payload[N:N-1] == 2'b00)); // R6
  AST_NO_RISE_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (s_rise[0] && !conv_start && !conv_done && !s_lvl[1] && $past(!s_lvl[1])) |=> $stable(sdo_data)); // R11
endmodule

// File: tb/adc_frame_serializer_bench.sv
module adc_frame_serializer_bench;
  localparam int RES_W   = 4;
  localparam int SUB_W   = 2;
  localparam int N       = RES_W + SUB_W;
  localparam int CODE_W  = N + 2;
  localparam int FRAME_W = N + 3;
  localparam int FS      = 1 << (N - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0;
  logic conv_done  = 1'b0;
  logic signed [CODE_W-1:0] conv_code = '0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdo_data, sdo_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_frame_serializer #(.RES_W(RES_W), .SUB_W(SUB_W)) u_adc_frame_serializer (
    .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
    .conv_code(conv_code), .sclk(sclk), .cs_n(cs_n),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_payload(input int v);
    if (v >= FS)  return 3 << (N - 1);
    if (v < -FS)  return FS - 1;
    return v + (1 << N);
  endfunction

  function automatic int frame_bit(input int v, input int k);
    int p;
    p = exp_payload(v);
    if (k == 1) return 0;
    if (k <= FRAME_W - 1) return (p >> (FRAME_W - 1 - k)) & 1;
    return 0;
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert(input int v);
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0; conv_code = CODE_W'(v); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic rise_only();
    sclk = 1'b1; waitn(4);
  endtask

  task automatic fall_only();
    sclk = 1'b0; waitn(4);
  endtask

  task automatic pulse();
    rise_only(); fall_only();
  endtask

  task automatic select();
    cs_n = 1'b0; waitn(5);
  endtask

  task automatic deselect();
    cs_n = 1'b1; waitn(5);
    chk("R2 oe off", int'(sdo_oe), 0);
    chk("R2 data quiet", int'(sdo_data), 0);
  endtask

  // Reads falls first..last of a frame already selected and started as needed.
  task automatic read_bits(input int v, input int first, input int last, input string tag);
    for (int k = first; k <= last; k++) begin
      pulse();
      chk(tag, int'(sdo_data), frame_bit(v, k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitn(5);
    rst = 1'b0;
    waitn(2);
    chk("R1 oe after reset", int'(sdo_oe), 0);
    select();
    chk("R1 oe when selected", int'(sdo_oe), 1);
    chk("R1 busy after reset", int'(sdo_data), 1);
    deselect();

    // R3: live busy flag with no serial clocks
    convert(7);
    select();
    chk("R3 idle flag", int'(sdo_data), 0);
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    waitn(2);
    chk("R3 flag rises", int'(sdo_data), 1);
    @(negedge clk); conv_code = CODE_W'(7); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    waitn(2);
    chk("R3 flag falls", int'(sdo_data), 0);
    deselect();

    // Exhaustive sweep: R4 R5 R6 R7 R8
    for (int c = -(1 << (CODE_W - 1)); c < (1 << (CODE_W - 1)); c++) begin
      convert(c);
      select();
      chk("R3 ready flag", int'(sdo_data), 0);
      for (int k = 1; k <= FRAME_W + 1; k++) begin
        pulse();
        if (k == 1)
          chk("R4 dummy bit", int'(sdo_data), 0);
        else if (k <= 3 && (c >= FS || c < -FS))
          chk("R6 range bits", int'(sdo_data), frame_bit(c, k));
        else if (k <= 3)
          chk("R5 sign/msb", int'(sdo_data), frame_bit(c, k));
        else if (k <= FRAME_W - 1)
          chk("R7 data bit", int'(sdo_data), frame_bit(c, k));
        else
          chk("R8 overrun zero", int'(sdo_data), 0);
      end
      deselect();
    end

    // R9: new result mid-frame does not disturb it
    convert(10);
    select();
    read_bits(10, 1, 3, "R9 before");
    convert(-20);
    read_bits(10, 4, FRAME_W - 1, "R9 frozen");
    deselect();

    // R10: abort and resend
    convert(-5);
    select();
    read_bits(-5, 1, 4, "R10 partial");
    deselect();
    select();
    chk("R10 flag again", int'(sdo_data), 0);
    read_bits(-5, 1, FRAME_W - 1, "R10 resent");
    deselect();

    // R2: clocks while deselected ignored
    convert(21);
    for (int i = 0; i < 3; i++) pulse();
    select();
    chk("R2 flag after idle clocks", int'(sdo_data), 0);
    read_bits(21, 1, FRAME_W - 1, "R2 frame intact");
    deselect();

    // R11: rising edges leave the line alone
    convert(-33);
    select();
    read_bits(-33, 1, 2, "R11 lead");
    rise_only();
    chk("R11 after rise", int'(sdo_data), frame_bit(-33, 2));
    fall_only();
    chk("R11 after fall", int'(sdo_data), frame_bit(-33, 3));
    deselect();

    // R12: falling edges while busy
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    select();
    chk("R12 busy shown", int'(sdo_data), 1);
    for (int i = 0; i < 3; i++) pulse();
    chk("R12 still busy", int'(sdo_data), 1);
    @(negedge clk); conv_code = CODE_W'(-1); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    waitn(3);
    chk("R12 ready", int'(sdo_data), 0);
    read_bits(-1, 1, FRAME_W - 1, "R12 frame after wait");
    deselect();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule